// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer of an 8-bit successive-approximation converter that sits on a microprocessor bus. It drives a trial code to an external ladder or DAC and reads back one comparator bit per step. The most significant bit is resolved first. When the last bit is resolved, the finished code goes into an output latch. One clock later an active-low interrupt is raised.

The bus side has three active-low strobes: chip select, write-start and read. Holding chip select and write low together keeps the converter in reset. A conversion is launched on a boundary of a free-running 8-clock phase counter once that condition has cleared. A new start during a conversion abandons it. A read with chip select low clears the interrupt and enables the data outputs. The tri-state bus is modelled as a data bus plus an output-enable pin.

Free-running operation works by tying the interrupt output back to the write input while chip select stays low. All strobes and data are plain pins; the block has no stream interface, so no back-pressure rules apply.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Every conversion begins with trial_o = 0x80, the most significant bit set alone.
- R2: Each bit is decided over a slot of 8 clocks, at the last clock of the slot. With cmp_i = 1 the trial bit is kept and with cmp_i = 0 it is cleared, and the next lower bit is then set. The finished code is latched 64 clocks after the launch.
- R3: cmp_i = 1 means the differential input is at or above trial_o. A comparator that always answers 1 yields 0xFF. A negative input at or above the positive input yields 0x00.
- R4: While cs_n and wr_n are both low (after synchronization), trial_o is 0, intr_n is 1 and no conversion starts, however long the condition lasts.
- R5: A conversion is launched 1 to 8 clocks after the released strobe leaves the two-flop synchronizer. This is 3 to 10 clocks after the raw release.
- R6: intr_n stays high throughout a conversion and falls exactly one clock after the result latch is written.
- R7: A start during a conversion aborts it. The aborted conversion produces no interrupt, and the new conversion delivers its own result.
- R8: A falling read strobe with cs_n low sets intr_n high within 3 clocks. A read with cs_n high leaves intr_n unchanged.
- R9: data_oe is 1 exactly when cs_n and rd_n are both low. data_o shows the latched code while data_oe is 1 and reads 0 otherwise.
- R10: With intr_n fed back to wr_n and cs_n held low, nothing starts after reset until one external write pulse is given. After that, conversions repeat with no further stimulus.
- R11: After reset, intr_n = 1, trial_o = 0, and data_o = 0 with the latch cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write-start strobe |
| rd_n | input | 1 | Active-low read strobe |
| cmp_i | input | 1 | Comparator result, 1 when input is at or above the trial code |
| trial_o | output | 8 | Trial code driven to the external ladder |
| data_o | output | 8 | Result data, 0 when not enabled |
| data_oe | output | 1 | Output enable of the modelled tri-state bus |
| intr_n | output | 1 | Active-low conversion-done interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- the start flip-flop holds the trial code at zero and the interrupt high (R4);
- every launch presents the MSB trial (R1);
- each bit step changes at most two trial bits (R2);
- the interrupt stays high while a conversion runs and falls only right after a latch write (R6);
- a fresh start flip-flop cancels a running conversion (R7).

Other behaviour only the bench scenarios can show, because it depends on an analog value that the bench models:
- the final codes, including the full-scale and reversed-input cases (R3);
- the launch window after release (R5);
- the exact interrupt cycle (R6);
- read clearing and the chip-select gating of reads (R8, R9);
- the self-sustaining free-running loop (R10).

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Conversion sequencer state
  typedef enum logic [1:0] {
    CV_IDLE = 2'd0,
    CV_HOLD = 2'd1,
    CV_RUN  = 2'd2
  } cv_state_e;

  localparam int unsigned DEF_CODE_W    = 8;
  localparam int unsigned DEF_SLOT_CLKS = 8;
  localparam int unsigned DEF_SYNC      = 2;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int unsigned N       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/sar_start.sv
module sar_start #(
  parameter int unsigned SLOT_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  output logic start_ff,
  output logic slot_end,
  output logic launch
);
  localparam int unsigned PH_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CLKS - 1);

  logic [PH_W-1:0] ph;

  // Free-running phase counter models the internal clock phases
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ph <= '0;
    else if (ph == PH_LAST) ph <= '0;
    else                  ph <= ph + 1'b1;
  end

  assign slot_end = (ph == PH_LAST);

  // Start flip-flop: set while request held, cleared only on a phase boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         start_ff <= 1'b0;
    else if (start_req) start_ff <= 1'b1;
    else if (slot_end)  start_ff <= 1'b0;
  end

  assign launch = start_ff && !start_req && slot_end;
endmodule

// File: rtl/sar_core.sv
module sar_core
  import sar_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              launch,
  input  logic              slot_end,
  input  logic              cmp_i,
  input  logic              rd_fall,
  output logic [CODE_W-1:0] trial,
  output logic [CODE_W-1:0] result,
  output logic              busy,
  output logic              done,
  output logic              intr_n
);
  localparam int unsigned IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [IDX_W-1:0]  IDX_MSB = IDX_W'(CODE_W - 1);
  localparam logic [CODE_W-1:0] MSB_ONE = {1'b1, {(CODE_W-1){1'b0}}};

  cv_state_e         state;
  logic [IDX_W-1:0]  idx;
  logic [CODE_W-1:0] trial_next;

  assign busy = (state == CV_RUN);

  // Decision for the current bit, then set the next lower one
  always_comb begin
    trial_next      = trial;
    trial_next[idx] = cmp_i;
    if (idx != '0) trial_next[idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= CV_IDLE;
      idx    <= IDX_MSB;
      trial  <= '0;
      result <= '0;
      done   <= 1'b0;
      intr_n <= 1'b1;
    end else begin
      done <= 1'b0;
      if (launch) begin
        state  <= CV_RUN;
        idx    <= IDX_MSB;
        trial  <= MSB_ONE;
        intr_n <= 1'b1;
      end else if (hold) begin
        state  <= CV_HOLD;
        idx    <= IDX_MSB;
        trial  <= '0;
        intr_n <= 1'b1;
      end else begin
        if (busy && slot_end) begin
          trial <= trial_next;
          if (idx != '0) begin
            idx <= idx - 1'b1;
          end else begin
            result <= trial_next;
            done   <= 1'b1;
            state  <= CV_IDLE;
          end
        end
        if (done)         intr_n <= 1'b0;
        else if (rd_fall) intr_n <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned CODE_W      = DEF_CODE_W,
  parameter int unsigned SLOT_CLKS   = DEF_SLOT_CLKS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] trial_o,
  output logic [CODE_W-1:0] data_o,
  output logic              data_oe,
  output logic              intr_n
);
  logic [2:0]        strb_s;
  logic              s_cs_n, s_wr_n, s_rd_n, s_rd_q;
  logic              start_req, start_ff, slot_end, launch;
  logic              rd_fall, busy, done;
  logic [CODE_W-1:0] result;

  sar_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({rd_n, wr_n, cs_n}), .q(strb_s)
  );
  assign {s_rd_n, s_wr_n, s_cs_n} = strb_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_rd_q <= 1'b1;
    else        s_rd_q <= s_rd_n;
  end

  assign start_req = !s_cs_n && !s_wr_n;
  assign rd_fall   = s_rd_q && !s_rd_n && !s_cs_n;

  sar_start #(.SLOT_CLKS(SLOT_CLKS)) u_start (
    .clk(clk), .rst_n(rst_n), .start_req(start_req),
    .start_ff(start_ff), .slot_end(slot_end), .launch(launch)
  );

  sar_core #(.CODE_W(CODE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .hold(start_ff), .launch(launch),
    .slot_end(slot_end), .cmp_i(cmp_i), .rd_fall(rd_fall),
    .trial(trial_o), .result(result), .busy(busy), .done(done),
    .intr_n(intr_n)
  );

  assign data_oe = !cs_n && !rd_n;
  assign data_o  = data_oe ? result : '0;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] trial_o,
  input logic              intr_n,
  input logic              start_ff,
  input logic              start_req,
  input logic              busy,
  input logic              done
);
  localparam logic [CODE_W-1:0] MSB_ONE = {1'b1, {(CODE_W-1){1'b0}}};

  a_r4_hold_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ff && start_req) |=> (trial_o == '0 && intr_n));

  a_r1_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (trial_o == MSB_ONE));

  a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($countones(trial_o ^ $past(trial_o)) <= 2));

  a_r6_high_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> intr_n);

  a_r6_fall_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(intr_n) |-> $past(done));

  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_ff) |=> !busy);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trial_o(trial_o), .intr_n(intr_n),
  .start_ff(start_ff), .start_req(start_req), .busy(busy), .done(done)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_drv = 1'b1, rd_n = 1'b1, ext_wr_n = 1'b1;
  logic       free_mode = 1'b0;
  logic       wr_n, cmp_i, data_oe, intr_n;
  logic [7:0] trial_o, data_o;
  int         vpos = 0, vneg = 0;
  int         n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  assign wr_n  = free_mode ? (intr_n & ext_wr_n) : wr_drv;
  assign cmp_i = (vpos - vneg) >= int'(trial_o);

  sar_adc_ctrl i_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cmp_i(cmp_i), .trial_o(trial_o), .data_o(data_o), .data_oe(data_oe),
    .intr_n(intr_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // R11 reset state
  task automatic t_reset();
    check("R11 intr_n", int'(intr_n), 1);
    check("R11 trial_o", int'(trial_o), 0);
    check("R11 data_oe", int'(data_oe), 0);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
    check("R11 latch cleared", int'(data_o), 0);
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  // Start, convert and read one result
  task automatic t_convert(input int p, input int m, input int hold, input int exp);
    int n;
    vpos = p; vneg = m;
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    repeat (hold) @(negedge clk);
    if (hold > 6) begin
      check("R4 trial held", int'(trial_o), 0);
      check("R4 intr held", int'(intr_n), 1);
    end
    cs_n = 1'b1; wr_drv = 1'b1;
    n = 0;
    while (trial_o == 8'h00 && n < 20) begin @(negedge clk); n++; end
    check("R5 launch window", int'(n >= 3 && n <= 10), 1);
    check("R1 msb first", int'(trial_o), 8'h80);
    repeat (63) @(negedge clk);
    check("R6 high during conversion", int'(intr_n), 1);
    @(negedge clk);
    check("R6 high at latch clock", int'(intr_n), 1);
    @(negedge clk);
    check("R6 falls one clock after latch", int'(intr_n), 0);
    cs_n = 1'b0; rd_n = 1'b0; #1;
    check("R9 oe on read", int'(data_oe), 1);
    check("R2 R3 result", int'(data_o), exp);
    repeat (3) @(negedge clk);
    check("R8 read clears intr", int'(intr_n), 1);
    rd_n = 1'b1; #1;
    check("R9 oe off", int'(data_oe), 0);
    check("R9 data zero off", int'(data_o), 0);
    cs_n = 1'b1;
  endtask

  // R8 read with cs high ignored
  task automatic t_read_no_cs();
    int n;
    vpos = 33; vneg = 0;
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; wr_drv = 1'b1;
    n = 0;
    while (intr_n == 1'b1 && n < 200) begin @(negedge clk); n++; end
    rd_n = 1'b0; #1;
    check("R9 oe needs cs", int'(data_oe), 0);
    repeat (5) @(negedge clk);
    check("R8 read without cs ignored", int'(intr_n), 0);
    rd_n = 1'b1; cs_n = 1'b0; @(negedge clk); rd_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 clear after cs read", int'(intr_n), 1);
    rd_n = 1'b1; cs_n = 1'b1;
  endtask

  // R7 abort mid-conversion
  task automatic t_abort();
    vpos = 240; vneg = 0;
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1; wr_drv = 1'b1;
    repeat (30) @(negedge clk);
    check("R7 running before abort", int'(trial_o != 0), 1);
    t_convert(77, 0, 4, 77);
  endtask

  // R10 free-running loop
  task automatic t_free();
    logic [7:0] t0;
    int n;
    int vals [3] = '{91, 200, 5};
    cs_n = 1'b0; free_mode = 1'b1; t0 = trial_o;
    repeat (40) @(negedge clk);
    check("R10 no start without pulse", int'(trial_o == t0 && intr_n), 1);
    vpos = vals[0]; vneg = 0;
    ext_wr_n = 1'b0; repeat (4) @(negedge clk); ext_wr_n = 1'b1;
    rd_n = 1'b0;
    for (int k = 0; k < 3; k++) begin
      n = 0;
      while (intr_n == 1'b1 && n < 300) begin @(negedge clk); n++; end
      check("R10 free-run result", int'(data_o), vals[k]);
      if (k < 2) vpos = vals[k+1];
      n = 0;
      while (intr_n == 1'b0 && n < 50) begin @(negedge clk); n++; end
    end
    free_mode = 1'b0; rd_n = 1'b1; cs_n = 1'b1;
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_convert(200, 72, 4, 128);
    t_convert(255, 0, 5, 255);   // R3 full scale
    t_convert(10, 200, 4, 0);    // R3 reversed input
    t_convert(100, 100, 40, 0);  // R3 equal inputs, R4 long hold
    t_convert(85, 0, 4, 85);     // R2 alternating bits
    t_read_no_cs();
    t_abort();
    t_free();
    finish_run();
  end
endmodule